// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a serial slave on a two-wire bus that keeps a small bank of 8-bit configuration registers and presents them as one flat parallel output to the logic around it. The bus clock and data lines are slow relative to the system clock. Both are brought through a flop synchronizer, and the slave finds start conditions, stop conditions and clock edges from the synchronized copies. The slave drives the data line only by asserting an output enable, which the pad pulls low.

After a matching address, the first byte is a command. A command with bit 7 set selects single-byte access at the offset in bits 6:0. A command with bit 7 clear selects block access beginning at register 0 and moving upward. A block write carries a byte count ahead of its data, and the slave ignores the value of that count. A block read starts with a count byte from the slave and then the registers in order. The master ends any transfer after any whole byte.

Top module: `cfg_smb_slave`

## Requirements
- R1: The slave answers only to the 7-bit address 1101001, which gives 0xD2 for write and 0xD3 for read. For any other address it acknowledges nothing, never drives the line and leaves every register unchanged until the next start condition.
- R2: Byte write is START, 0xD2, command with bit 7 = 1 and bits 6:0 = offset, data, STOP. It loads the data into the register at that offset. The slave acknowledges each of the three bytes.
- R3: Byte read is START, 0xD2, command with bit 7 = 1 and offset, repeated START, 0xD3. The slave then returns the register at that offset, most significant bit first. The master NACKs that byte and sends STOP.
- R4: Block write is START, 0xD2, command 0x00, count byte, then data. The data bytes go to registers 0, 1, 2 in that order. The slave acknowledges every byte. A STOP after any whole data byte keeps the registers already written and leaves the rest unchanged.
- R5: Block read is START, 0xD2, command 0x00, repeated START, 0xD3. The slave then sends the count byte 0x03 followed by registers 0, 1, 2. After the master NACKs a byte, the slave stops driving the data line.
- R6: After reset the parallel output `cfg_q` is 0xFFC0FF. Register 0 is bits 7:0, register 1 is bits 15:8 and register 2 is bits 23:16.
- R7: A single-byte access at an offset of 3 or more is acknowledged. A write there changes no register, and a read there returns 0x00.
- R8: A STOP received after two or more clock rises into a byte abandons the transfer. A START received at that point also abandons it and returns the slave to idle, and the slave then acknowledges nothing until a fresh START. Registers written earlier in the transfer keep their values.
- R9: The slave changes its line drive only in response to a falling bus clock, a START or a STOP. It holds the drive low (released) whenever it is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level from the pad |
| sda_i | input | 1 | Bus data level from the pad (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls the bus data line low; 0 releases it |
| cfg_q | output | 24 | Register bank contents, register 0 in the low byte |

## Verification
The assertions assume that each bus line is a clean digital level that holds for at least a few system clocks between transitions. They also assume that the master changes the data line only while the bus clock is low, except when it makes a START or STOP. If those assumptions fail, the synchronized clock edges and the start/stop flags can arrive out of order, and the drive-timing property would no longer describe the bus. The master model in the bench holds every bus phase for eight system clocks. It combines its own pull-down and the slave's output enable as a wired-AND, and it moves the data line only at quarter points of the low half of the clock. The only exceptions are the deliberate start and stop conditions.

// File: rtl/cfg_smb_pkg.sv
package cfg_smb_pkg;

   // protocol position of the slave within a transfer
   typedef enum logic [2:0] {
      PH_IDLE,    // not addressed, ignores clock edges
      PH_ADDR,    // receiving the address byte
      PH_CMD,     // receiving the command byte
      PH_COUNT,   // receiving the block-write count byte
      PH_DATA,    // receiving data bytes
      PH_TX,      // transmitting bytes to the master
      PH_WAIT     // not participating until START or STOP
   } smb_phase_e;

   localparam int BYTE_W = 8;

endpackage

// File: rtl/smb_line_cond.sv
module smb_line_cond #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic [STAGES-1:0] scl_sh, sda_sh;
   logic              scl_p, sda_p;
   logic              scl_s, sda_s;

   // synchronizer chain, depth chosen by parameter
   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_sh <= '1;
               sda_sh <= '1;
            end else begin
               scl_sh <= scl_i;
               sda_sh <= sda_i;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_sh <= '1;
               sda_sh <= '1;
            end else begin
               scl_sh <= {scl_sh[STAGES-2:0], scl_i};
               sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            end
         end
      end
   endgenerate

   assign scl_s = scl_sh[STAGES-1];
   assign sda_s = sda_sh[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign sda_lvl   = sda_s;
   assign scl_rise  = scl_s & ~scl_p;
   assign scl_fall  = ~scl_s & scl_p;
   assign start_det = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
   parameter int                 NREG    = 3,
   parameter int                 IDX_W   = 7,
   parameter logic [NREG*8-1:0]  RST_VAL = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [7:0]        wr_dat,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [7:0]        rd_dat,
   output logic [NREG*8-1:0] q
);

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q[g*8 +: 8] <= RST_VAL[g*8 +: 8];
            else if (wr_en && wr_idx == IDX_W'(g))
               q[g*8 +: 8] <= wr_dat;
         end
      end
   endgenerate

   // offsets past the bank read as zero
   always_comb begin
      rd_dat = 8'h00;
      for (int i = 0; i < NREG; i++)
         if (rd_idx == IDX_W'(i)) rd_dat = q[i*8 +: 8];
   end

   AST_WR_IN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_idx < IDX_W'(NREG)));                                 // R7
   AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(q));                                             // R1

endmodule

// File: rtl/cfg_smb_slave.sv
module cfg_smb_slave
   import cfg_smb_pkg::*;
#(
   parameter logic [6:0]        DEV_ADDR    = 7'b1101001,
   parameter int                NREG        = 3,
   parameter logic [NREG*8-1:0] RST_VAL     = 24'hFF_C0_FF,
   parameter int                SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic [NREG*8-1:0] cfg_q
);

   localparam int         IDX_W  = 7;
   localparam logic [6:0] NREG_I = IDX_W'(NREG);
   localparam logic [7:0] CNT_B  = 8'(NREG);

   generate
      if (NREG < 1 || NREG > 127) begin : g_bad_nreg
         $error("NREG must lie in 1..127");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;

   smb_line_cond #(.STAGES(SYNC_STAGES)) u_line (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   smb_phase_e       phase;
   logic [3:0]       cnt;       // clock rises seen in the current byte
   logic [7:0]       sreg;      // receive shifter
   logic [7:0]       txs;       // transmit shifter
   logic [IDX_W-1:0] ptr;       // register pointer
   logic             blk;       // last command selected block access
   logic             send_cnt;  // next transmitted byte is the count
   logic             mack;      // master acknowledged the last byte
   logic             wr_en;
   logic [IDX_W-1:0] wr_idx;
   logic [7:0]       wr_dat;
   logic [7:0]       rd_dat;
   logic [7:0]       tx_next;
   logic             bnd;       // START counts as a byte boundary

   assign tx_next = send_cnt ? CNT_B : rd_dat;
   assign bnd     = (phase == PH_IDLE) || (phase == PH_WAIT) || (cnt <= 4'd1);

   smb_reg_bank #(.NREG(NREG), .IDX_W(IDX_W), .RST_VAL(RST_VAL)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_dat(wr_dat), .rd_idx(ptr), .rd_dat(rd_dat), .q(cfg_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         cnt      <= 4'd0;
         sreg     <= 8'h00;
         txs      <= 8'h00;
         ptr      <= '0;
         blk      <= 1'b0;
         send_cnt <= 1'b0;
         mack     <= 1'b0;
         sda_oe   <= 1'b0;
         wr_en    <= 1'b0;
         wr_idx   <= '0;
         wr_dat   <= 8'h00;
      end else begin
         wr_en <= 1'b0;
         if (stop_det) begin
            phase  <= PH_IDLE;
            cnt    <= 4'd0;
            sda_oe <= 1'b0;
         end else if (start_det) begin
            phase  <= bnd ? PH_ADDR : PH_IDLE;
            cnt    <= 4'd0;
            sda_oe <= 1'b0;
         end else if (phase != PH_IDLE) begin
            if (scl_rise) begin
               if (cnt < 4'd8) sreg <= {sreg[6:0], sda_lvl};
               // in the address ack slot this samples the slave's own low drive
               if (cnt == 4'd8 && phase == PH_TX) mack <= ~sda_lvl;
               if (cnt != 4'd9) cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
               if (cnt == 4'd8) begin
                  unique case (phase)
                     PH_ADDR: begin
                        if (sreg[7:1] == DEV_ADDR) begin
                           sda_oe <= 1'b1;
                           if (sreg[0]) begin
                              phase    <= PH_TX;
                              send_cnt <= blk;
                           end else begin
                              phase <= PH_CMD;
                           end
                        end else begin
                           phase <= PH_WAIT;
                        end
                     end
                     PH_CMD: begin
                        sda_oe <= 1'b1;
                        blk    <= ~sreg[7];
                        ptr    <= sreg[7] ? sreg[6:0] : '0;
                        phase  <= sreg[7] ? PH_DATA : PH_COUNT;
                     end
                     PH_COUNT: begin
                        sda_oe <= 1'b1;
                        phase  <= PH_DATA;
                     end
                     PH_DATA: begin
                        sda_oe <= 1'b1;
                        wr_en  <= (ptr < NREG_I);
                        wr_idx <= ptr;
                        wr_dat <= sreg;
                        ptr    <= ptr + 7'd1;
                     end
                     PH_TX:   sda_oe <= 1'b0;
                     default: ;
                  endcase
               end else if (cnt == 4'd9) begin
                  cnt <= 4'd0;
                  if (phase == PH_TX && mack) begin
                     txs    <= tx_next;
                     sda_oe <= ~tx_next[7];
                     if (send_cnt) send_cnt <= 1'b0;
                     else          ptr      <= ptr + 7'd1;
                  end else begin
                     sda_oe <= 1'b0;
                     if (phase == PH_TX) phase <= PH_WAIT;
                  end
               end else if (phase == PH_TX && cnt != 4'd0) begin
                  txs    <= {txs[6:0], 1'b0};
                  sda_oe <= ~txs[6];
               end
            end
         end
      end
   end

   AST_DRIVE_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> $past(scl_fall || start_det || stop_det)); // R9
   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE) |-> !sda_oe);                                     // R9
   AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (phase == PH_IDLE));                                    // R8
   AST_WAIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_WAIT) |-> !sda_oe);                                     // R1

endmodule

// File: tb/sim_cfg_smb_slave.sv
module sim_cfg_smb_slave;

   localparam int Q = 8;  // system clocks per quarter bus bit

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        m_scl = 1'b1;
   logic        m_oe = 1'b0;
   logic        sda_oe;
   logic [23:0] cfg_q;
   wire         sda_bus = ~(m_oe | sda_oe);

   int   n_chk = 0;
   int   n_err = 0;
   logic done = 1'b0;
   logic [7:0] mdl [3];

   always #4 clk = ~clk;

   cfg_smb_slave u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
      .sda_oe(sda_oe), .cfg_q(cfg_q)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic qw(input int n);
      repeat (n * Q) @(negedge clk);
   endtask

   task automatic bit_out(input logic b);
      qw(1); m_oe = ~b; qw(1); m_scl = 1'b1; qw(2); m_scl = 1'b0;
   endtask

   task automatic bit_in(output logic b);
      m_oe = 1'b0; qw(2); m_scl = 1'b1; qw(1); b = sda_bus; qw(1); m_scl = 1'b0;
   endtask

   task automatic do_start();
      qw(1); m_oe = 1'b1; qw(1); m_scl = 1'b0;
   endtask

   task automatic do_rstart();
      qw(1); m_oe = 1'b0; qw(1); m_scl = 1'b1; qw(1); m_oe = 1'b1; qw(1); m_scl = 1'b0;
   endtask

   task automatic do_stop();
      qw(1); m_oe = 1'b1; qw(1); m_scl = 1'b1; qw(1); m_oe = 1'b0; qw(2);
   endtask

   task automatic wr_byte(input logic [7:0] b, output logic ack);
      logic a;
      for (int i = 7; i >= 0; i--) bit_out(b[i]);
      bit_in(a);
      ack = ~a;
   endtask

   task automatic rd_byte(input logic ack, output logic [7:0] d);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         bit_in(b);
         d[i] = b;
      end
      bit_out(~ack);
   endtask

   task automatic byte_write(input logic [7:0] cmd, input logic [7:0] dat, output logic [2:0] acks);
      do_start();
      wr_byte(8'hD2, acks[2]);
      wr_byte(cmd, acks[1]);
      wr_byte(dat, acks[0]);
      do_stop();
   endtask

   task automatic byte_read(input logic [7:0] cmd, output logic [7:0] d, output logic [2:0] acks);
      do_start();
      wr_byte(8'hD2, acks[2]);
      wr_byte(cmd, acks[1]);
      do_rstart();
      wr_byte(8'hD3, acks[0]);
      rd_byte(1'b0, d);
      do_stop();
   endtask

   function automatic logic [23:0] mdl_q();
      return {mdl[2], mdl[1], mdl[0]};
   endfunction

   // {command, write data, expected readback}
   localparam logic [23:0] VEC [6] = '{
      24'h80_5A_5A, 24'h81_3C_3C, 24'h82_A5_A5,
      24'h85_77_00, 24'hFF_12_00, 24'h80_01_01
   };

   initial begin
      logic [2:0] acks;
      logic [7:0] d;
      logic       a;
      mdl[0] = 8'hFF; mdl[1] = 8'hC0; mdl[2] = 8'hFF;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R6 reset state, R9 released while idle
      chk("R6 reset contents", cfg_q, 24'hFFC0FF);
      chk("R9 idle release", sda_oe, 1'b0);

      // table of single-byte write/read pairs (R2 R3 R7)
      for (int i = 0; i < 6; i++) begin
         logic [7:0] c, w, e;
         string t;
         c = VEC[i][23:16]; w = VEC[i][15:8]; e = VEC[i][7:0];
         t = (c[6:0] < 7'd3) ? "R2" : "R7";
         byte_write(c, w, acks);
         chk({t, " write acks"}, acks, 3'b111);
         if (c[6:0] < 7'd3) mdl[c[1:0]] = w;
         chk({t, " contents after write"}, cfg_q, mdl_q());
         byte_read(c, d, acks);
         chk((c[6:0] < 7'd3) ? "R3 readback" : "R7 readback", d, e);
         chk("R3 read acks", acks, 3'b111);
      end

      // R1 foreign address: no ack, nothing written
      do_start();
      wr_byte(8'hA0, a);
      chk("R1 foreign address nack", a, 1'b0);
      wr_byte(8'h81, a);
      chk("R1 no ack after mismatch", a, 1'b0);
      wr_byte(8'hEE, a);
      do_stop();
      chk("R1 contents kept", cfg_q, mdl_q());

      // R4 full block write
      do_start();
      wr_byte(8'hD2, acks[2]);
      wr_byte(8'h00, acks[1]);
      wr_byte(8'h03, acks[0]);
      chk("R4 header acks", acks, 3'b111);
      wr_byte(8'h11, acks[0]);
      wr_byte(8'h22, acks[1]);
      wr_byte(8'h33, acks[2]);
      chk("R4 data acks", acks, 3'b111);
      do_stop();
      mdl[0] = 8'h11; mdl[1] = 8'h22; mdl[2] = 8'h33;
      chk("R4 block write", cfg_q, mdl_q());

      // R4 block write stopped after one data byte
      do_start();
      wr_byte(8'hD2, a);
      wr_byte(8'h00, a);
      wr_byte(8'h03, a);
      wr_byte(8'h44, a);
      do_stop();
      mdl[0] = 8'h44;
      chk("R4 early stop", cfg_q, mdl_q());

      // R5 block read: count then registers, NACK on last
      do_start();
      wr_byte(8'hD2, acks[2]);
      wr_byte(8'h00, acks[1]);
      do_rstart();
      wr_byte(8'hD3, acks[0]);
      chk("R5 acks", acks, 3'b111);
      rd_byte(1'b1, d);
      chk("R5 count byte", d, 8'h03);
      rd_byte(1'b1, d);
      chk("R5 reg0", d, mdl[0]);
      rd_byte(1'b1, d);
      chk("R5 reg1", d, mdl[1]);
      rd_byte(1'b0, d);
      chk("R5 reg2", d, mdl[2]);
      qw(1);
      chk("R5 released after nack", sda_oe, 1'b0);
      do_stop();

      // R8 stop in the middle of a data byte
      do_start();
      wr_byte(8'hD2, a);
      wr_byte(8'h81, a);
      for (int i = 0; i < 4; i++) bit_out(1'b0);
      do_stop();
      chk("R8 mid-byte stop keeps reg", cfg_q, mdl_q());

      // R8 start in the middle of a byte, then address without a new start
      do_start();
      wr_byte(8'hD2, a);
      for (int i = 0; i < 3; i++) bit_out(1'b1);
      do_rstart();
      wr_byte(8'hD2, a);
      chk("R8 no ack after abort", a, 1'b0);
      do_stop();

      // fresh transfer works after the abort
      byte_write(8'h82, 8'h99, acks);
      mdl[2] = 8'h99;
      chk("R8 recovery acks", acks, 3'b111);
      chk("R8 recovery contents", cfg_q, mdl_q());
      chk("R9 idle at end", sda_oe, 1'b0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule